// File: doc/BRIEF.md
# Two-Key Sequence Watchdog Timer

This block is a watchdog that is inert after reset. It neither counts nor requests a reset until software sets its enable bit. From then on, a down-counter loses one per clock cycle. Software keeps it alive by writing two fixed 16-bit service codes to the key register in two separate writes. The first code is 0xE51A and the second is 0xA35C. When the pair completes, the counter is reloaded from the programmed reload value. If software stops servicing and the counter is found at zero, the block raises a reset request for a fixed number of cycles, so that the system restarts. At the same moment it returns to the disabled state with the counter reloaded.

The register port has a write side (strobe, address, data) and an independent, purely combinational read side (address in, data out). Four addresses exist:

| Address | Register | Write | Read |
|---|---|---|---|
| 0 | control | bit 0 = 1 sets the enable | bit 0 = enable |
| 1 | reload | sets the reload value | reload value |
| 2 | key | service code | bit 0 = armed (first code seen) |
| 3 | count | no effect | current count |

Top module: `wdt_twokey`

## Requirements
- R1: After reset the enable reads 0, the count and the reload register both read DEF_RELOAD (200 by default), the armed bit reads 0 and the reset request is low.
- R2: While disabled, the block never raises the reset request. On each clock the count is loaded with the reload register, so a reload value written at address 1 appears at address 3 one cycle after the write.
- R3: Writing a value with bit 0 = 1 to address 0 sets the enable. The count then falls by exactly one per clock. Writing bit 0 = 0 to address 0 does not disable the block.
- R4: Writing 0xE51A and then, in a later write, 0xA35C to address 2 reloads the count on the edge of the second write. The new count equals the reload register at that moment. Changing the reload register while enabled does not alter the running count.
- R5: A 0xA35C key write that is not preceded by 0xE51A has no effect: the count keeps decrementing.
- R6: After 0xE51A, a key write of any value other than the two codes clears the armed bit. A following 0xA35C then does not reload the count.
- R7: A second 0xE51A while armed keeps the block armed, and a following 0xA35C completes the service.
- R8: On a clock edge where the block is enabled and the count is zero, the reset request goes high for exactly RST_CYCLES (4 by default) consecutive cycles. On that same edge the block becomes disabled, the armed bit clears and the count is reloaded. Enable writes made while the request is high are ignored.
- R9: When a completing 0xA35C write falls on the edge where the count is 1, the service wins: the count is reloaded and no reset is requested. When it falls on the edge where the count is 0, expiry wins: the reset request is raised and the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | Write address (0 control, 1 reload, 2 key, 3 count) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 32 | Combinational read data for rd_addr |
| wdt_rst_o | output | 1 | Reset request pulse |

## Verification
Service completion and counter expiry can fall on the same clock edge. That edge is the one where the second code is written while the count reads zero. The bench provokes it by arming with the first code and polling the count down to 0 or 1. It then issues the second code on exactly that edge. It judges the outcome from the reset request, the enable bit and the reloaded count, which must show expiry winning at zero and the service winning at one. The enable write during an active reset pulse is handled in the same way. It overlaps the pulse and the disable, and it must leave the block disabled.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W = 32;
    localparam int KEY_W  = 16;
    localparam int ADDR_W = 2;

    localparam logic [KEY_W-1:0] KEY_FIRST  = 16'hE51A;
    localparam logic [KEY_W-1:0] KEY_SECOND = 16'hA35C;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_KEY    = 2'd2,
        REG_COUNT  = 2'd3
    } wdt_reg_e;

    typedef enum logic {
        KS_IDLE  = 1'b0,
        KS_ARMED = 1'b1
    } keyseq_e;

    typedef struct packed {
        logic              valid;
        wdt_reg_e          target;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic hits(input wr_req_t req, input wdt_reg_e r);
        return req.valid && (req.target == r);
    endfunction

    function automatic logic [KEY_W-1:0] key_field(input wr_req_t req);
        return req.data[KEY_W-1:0];
    endfunction

endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    input  logic             clr,
    output logic             armed,
    output logic             done
);

    keyseq_e state_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= KS_IDLE;
        end else if (key_wr) begin
            if (key_val == KEY_FIRST) begin
                state_q <= KS_ARMED;
            end else begin
                state_q <= KS_IDLE;
            end
        end
    end

    assign armed = (state_q == KS_ARMED);
    assign done  = key_wr && armed && (key_val == KEY_SECOND);

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int              CNT_W      = 16,
    parameter logic [CNT_W-1:0] DEF_RELOAD = 16'd200
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           req,
    input  logic              expire,
    input  logic              pulse_busy,
    input  wdt_reg_e          rd_sel,
    input  logic [CNT_W-1:0]  count,
    input  logic              armed,
    output logic              en,
    output logic [CNT_W-1:0]  reload,
    output logic [DATA_W-1:0] rd_data
);

    logic unused_data;
    assign unused_data = ^req.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= 1'b0;
        end else if (expire) begin
            en <= 1'b0;
        end else if (hits(req, REG_CTRL) && req.data[0] && !pulse_busy) begin
            en <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= DEF_RELOAD;
        end else if (hits(req, REG_RELOAD)) begin
            reload <= req.data[CNT_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            REG_CTRL:   rd_data[0] = en;
            REG_RELOAD: rd_data = DATA_W'(reload);
            REG_KEY:    rd_data[0] = armed;
            REG_COUNT:  rd_data = DATA_W'(count);
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int               CNT_W      = 16,
    parameter logic [CNT_W-1:0] DEF_RELOAD = 16'd200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             service,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    assign expire = en && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= DEF_RELOAD;
        end else if (!en || expire) begin
            count <= reload;
        end else if (service) begin
            count <= reload;
        end else begin
            count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/wdt_rstpulse.sv
module wdt_rstpulse #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic req
);

    localparam int PW = $clog2(RST_CYCLES + 1);
    localparam logic [PW-1:0] LEN = PW'(RST_CYCLES);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= LEN;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign req = (left_q != '0);

endmodule

// File: rtl/wdt_twokey.sv
module wdt_twokey
    import wdt_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter logic [CNT_W-1:0] DEF_RELOAD = 16'd200,
    parameter int               RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wdt_rst_o
);

    wr_req_t          req;
    logic             en_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    logic             expire;
    logic             armed;
    logic             svc_done;

    assign req.valid  = wr_en;
    assign req.target = wdt_reg_e'(wr_addr);
    assign req.data   = wr_data;

    wdt_regs #(.CNT_W(CNT_W), .DEF_RELOAD(DEF_RELOAD)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .expire     (expire),
        .pulse_busy (wdt_rst_o),
        .rd_sel     (wdt_reg_e'(rd_addr)),
        .count      (count_q),
        .armed      (armed),
        .en         (en_q),
        .reload     (reload_q),
        .rd_data    (rd_data)
    );

    wdt_keyseq u_keyseq (
        .clk     (clk),
        .rst     (rst),
        .key_wr  (hits(req, REG_KEY)),
        .key_val (key_field(req)),
        .clr     (expire),
        .armed   (armed),
        .done    (svc_done)
    );

    wdt_counter #(.CNT_W(CNT_W), .DEF_RELOAD(DEF_RELOAD)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .en      (en_q),
        .service (svc_done),
        .reload  (reload_q),
        .count   (count_q),
        .expire  (expire)
    );

    wdt_rstpulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk  (clk),
        .rst  (rst),
        .fire (expire),
        .req  (wdt_rst_o)
    );

endmodule

// File: rtl/wdt_twokey_chk.sv
module wdt_twokey_chk
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int RST_CYCLES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              en_q,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W-1:0]  reload_q,
    input logic              svc_done,
    input logic              armed,
    input logic              wdt_rst_o
);

    localparam int HW = $clog2(RST_CYCLES + 2) + 1;

    logic [HW-1:0] hi_cnt;
    logic          key_wr;

    assign key_wr = wr_en && (wr_addr == REG_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
        end else if (wdt_rst_o) begin
            hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    // R2: a disabled block tracks the reload register
    assert_disabled_tracks_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(en_q) |-> (count_q == $past(reload_q)));

    // R3: enable is sticky until expiry
    assert_enable_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (en_q && count_q != '0) |=> en_q);

    // R3: one step per cycle while running and unserviced
    assert_decrement_R3: assert property (@(posedge clk) disable iff (rst)
        (en_q && count_q != '0 && !svc_done) |=> (count_q == $past(count_q) - 1'b1));

    // R4: completed pair reloads
    assert_service_reload_R4: assert property (@(posedge clk) disable iff (rst)
        (en_q && count_q != '0 && svc_done) |=> (count_q == $past(reload_q)));

    // R5, R7: arming only from a first-code write
    assert_arm_source_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> ($past(key_wr) && $past(wr_data[KEY_W-1:0]) == KEY_FIRST));

    // R6: a foreign key value disarms
    assert_foreign_disarm_R6: assert property (@(posedge clk) disable iff (rst)
        (key_wr && wr_data[KEY_W-1:0] != KEY_FIRST && wr_data[KEY_W-1:0] != KEY_SECOND)
        |=> !armed);

    // R8: request only from an enabled zero count
    assert_request_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_rst_o) |-> ($past(en_q) && $past(count_q) == '0));

    // R8: pulse never longer than the fixed width
    assert_pulse_max_R8: assert property (@(posedge clk) disable iff (rst)
        hi_cnt <= HW'(RST_CYCLES));

    // R8: pulse ends only at the fixed width
    assert_pulse_len_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(wdt_rst_o) |-> (hi_cnt == HW'(RST_CYCLES)));

    // R9: expiry disables even with a simultaneous service
    assert_expiry_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (en_q && count_q == '0) |=> (!en_q && wdt_rst_o));

endmodule

bind wdt_twokey wdt_twokey_chk #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .en_q      (en_q),
    .count_q   (count_q),
    .reload_q  (reload_q),
    .svc_done  (svc_done),
    .armed     (armed),
    .wdt_rst_o (wdt_rst_o)
);

// File: tb/tb_wdt_twokey.sv
`timescale 1ns/1ps
module tb_wdt_twokey;

    localparam int CLK_PERIOD = 10;
    localparam int RLD = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wdt_rst_o;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    wdt_twokey dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wdt_rst_o (wdt_rst_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // called at a negedge (or just after); one write edge, returns after next negedge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_count(input logic [31:0] v);
        logic [31:0] c;
        for (int i = 0; i < 200; i++) begin
            rd(2'd3, c);
            if (c == v) return;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_cycles(3);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // reset, program reload RLD, enable; returns at a negedge with count RLD
    task automatic prep();
        do_reset();
        wr(2'd1, RLD);
        @(negedge clk);
        wr(2'd0, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(2'd0, v); chk("R1 enable", v, 0);
        rd(2'd3, v); chk("R1 count", v, 200);
        rd(2'd1, v); chk("R1 reload", v, 200);
        rd(2'd2, v); chk("R1 armed", v, 0);
        chk("R1 request", wdt_rst_o, 0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        int hi = 0;
        for (int i = 0; i < 250; i++) begin
            @(negedge clk);
            if (wdt_rst_o) hi++;
        end
        chk("R2 no request while disabled", hi, 0);
        rd(2'd3, v); chk("R2 count held", v, 200);
        wr(2'd1, 32'd37);
        @(negedge clk);
        rd(2'd3, v); chk("R2 count follows reload", v, 37);
    endtask

    task automatic t_count();
        logic [31:0] v;
        prep();
        rd(2'd0, v); chk("R3 enabled", v, 1);
        rd(2'd3, v); chk("R3 start count", v, RLD);
        wait_cycles(5);
        rd(2'd3, v); chk("R3 decrement", v, RLD - 5);
        wr(2'd0, 32'd0);
        rd(2'd0, v); chk("R3 not disabled by zero", v, 1);
        rd(2'd3, v); chk("R3 still counting", v, RLD - 6);
    endtask

    task automatic t_service();
        logic [31:0] v;
        prep();
        wr(2'd2, 32'hE51A);
        rd(2'd2, v); chk("R4 armed after first code", v, 1);
        wr(2'd2, 32'hA35C);
        rd(2'd3, v); chk("R4 pair reloads", v, RLD);
        wr(2'd1, 32'd30);
        rd(2'd3, v); chk("R4 reload write keeps count", v, RLD - 1);
        wr(2'd2, 32'hE51A);
        wr(2'd2, 32'hA35C);
        rd(2'd3, v); chk("R4 new reload used", v, 30);
    endtask

    task automatic t_lone_second();
        logic [31:0] v;
        prep();
        wait_cycles(2);
        wr(2'd2, 32'hA35C);
        rd(2'd3, v); chk("R5 lone second code ignored", v, RLD - 3);
        rd(2'd2, v); chk("R5 not armed", v, 0);
    endtask

    task automatic t_foreign();
        logic [31:0] v;
        prep();
        wr(2'd2, 32'hE51A);
        wr(2'd2, 32'h1234);
        rd(2'd2, v); chk("R6 foreign value disarms", v, 0);
        wr(2'd2, 32'hA35C);
        rd(2'd3, v); chk("R6 no reload after disarm", v, RLD - 3);
    endtask

    task automatic t_double_first();
        logic [31:0] v;
        prep();
        wr(2'd2, 32'hE51A);
        wr(2'd2, 32'hE51A);
        rd(2'd2, v); chk("R7 still armed", v, 1);
        wr(2'd2, 32'hA35C);
        rd(2'd3, v); chk("R7 service completes", v, RLD);
    endtask

    task automatic t_expire();
        logic [31:0] v;
        int n;
        int late = 0;
        prep();
        wait_count(0);
        chk("R8 low at zero count", wdt_rst_o, 0);
        @(negedge clk);
        chk("R8 request raised", wdt_rst_o, 1);
        rd(2'd0, v); chk("R8 disabled", v, 0);
        rd(2'd3, v); chk("R8 count reloaded", v, RLD);
        wr(2'd0, 32'd1);
        n = 1;
        if (wdt_rst_o) n++;
        for (int i = 0; i < 20 && wdt_rst_o; i++) begin
            @(negedge clk);
            if (wdt_rst_o) n++;
        end
        chk("R8 pulse width", n, 4);
        rd(2'd0, v); chk("R8 enable during pulse ignored", v, 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (wdt_rst_o) late++;
        end
        chk("R8 no further request", late, 0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        prep();
        wr(2'd2, 32'hE51A);
        wait_count(1);
        wr(2'd2, 32'hA35C);
        rd(2'd3, v); chk("R9 service at one reloads", v, RLD);
        chk("R9 no request at one", wdt_rst_o, 0);
        rd(2'd0, v); chk("R9 still enabled", v, 1);
        wr(2'd2, 32'hE51A);
        wait_count(0);
        wr(2'd2, 32'hA35C);
        chk("R9 expiry wins at zero", wdt_rst_o, 1);
        rd(2'd0, v); chk("R9 disabled at zero", v, 0);
        rd(2'd2, v); chk("R9 disarmed at zero", v, 0);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_count();
        t_service();
        t_lone_second();
        t_foreign();
        t_double_first();
        t_expire();
        t_race();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog timeout actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule